// File: doc/BRIEF.md
# Key-Combination Reset Generator

This block turns a held key chord into a system reset pulse. A keypad front end outside the block supplies one pressed flag per key. The flags are indexed by an event code, so code `n` refers to flag `n`. The block runs two independent generators. The first arms on three programmed codes and the second on two. A generator fires only when every programmed key of its chord is down at the same time and stays down for a selectable hold time. It then drives a reset pulse of selectable width.

Both generators share one hold-time field, one pulse-width field and an output polarity bit. The first generator can also pass an external active-low reset input through to its own output. A code of zero leaves its slot unused. After a pulse, the chord must be let go and pressed again before the same generator can fire a second time. This lets a user recover a hung system from the keypad without removing power.

Top module: `keyComboReset`

## Requirements
- R1: Generator 1 starts a pulse only when the pressed flags of all its nonzero codes (`g1CodeA`, `g1CodeB`, `g1CodeC`) are high together; any strict subset of those keys never fires it.
- R2: Generator 2 behaves the same way on its two codes `g2CodeA` and `g2CodeB`; one key alone never fires it.
- R3: A code of 0 marks its slot unused, and that slot always counts as satisfied. A generator whose codes are all 0 never fires, whatever keys are pressed.
- R4: Let `H = trigTime * HOLD_DIV` clock cycles, where `trigTime` runs from 0 to 7 and `HOLD_DIV` is the number of cycles in one hold unit. If the chord is first seen at rising edge t and stays held, the output asserts after edge t+H. With `trigTime = 0` it asserts right after edge t.
- R5: If any key of the chord is released before the hold expires, the hold count is discarded. A later press must then wait the full hold time again.
- R6: Let `pulseWidth` encodings 0, 1, 2 and 3 stand for 0.5, 1, 2 and 4 units, where `PULSE_DIV` is the number of cycles in half a unit. The pulse lasts exactly `PULSE_DIV << pulseWidth` cycles.
- R7: Once a pulse starts it runs its full width, even if the keys are released during it.
- R8: While the chord stays held after a pulse, no second pulse fires. Releasing the chord and pressing it again fires a new pulse.
- R9: With `activeHigh = 0` an asserted output is driven 0 and an idle output is driven 1. With `activeHigh = 1` the levels are inverted. Both outputs are idle after reset.
- R10: When `passThruEn = 1` and `extRstN = 0`, `rst1Out` is asserted. The external input never affects `rst2Out`, and it has no effect on `rst1Out` when `passThruEn = 0`.
- R11: The two generators are independent: a pulse on one output leaves the other output idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| keyPressed | input | 2**CODE_W | Per-key pressed flags, indexed by event code |
| g1CodeA | input | CODE_W | Generator 1, first chord key |
| g1CodeB | input | CODE_W | Generator 1, second chord key |
| g1CodeC | input | CODE_W | Generator 1, third chord key |
| g2CodeA | input | CODE_W | Generator 2, first chord key |
| g2CodeB | input | CODE_W | Generator 2, second chord key |
| trigTime | input | 3 | Hold time, in units of HOLD_DIV cycles |
| pulseWidth | input | 2 | Pulse width code (0.5, 1, 2 or 4 units) |
| passThruEn | input | 1 | Route extRstN onto rst1Out |
| extRstN | input | 1 | External active-low reset input |
| activeHigh | input | 1 | Output polarity select |
| rst1Out | output | 1 | Generator 1 reset output |
| rst2Out | output | 1 | Generator 2 reset output |

## Verification
The timing sweep covers all 32 pairs of hold code and width code. For each pair it measures the cycle where the output first asserts and the number of asserted cycles, so an off-by-one in either counter is caught separately. Key subsets of each chord are tried one by one: only the full set may fire, which exposes a missing slot term in the match. Further patterns cover release mid-hold, release mid-pulse, a chord held long after its pulse, unused zero slots, both polarities and the external pass-through. Each of these separates a state-machine path that the plain sweep never takes.

// File: rtl/krgPkg.sv
package krgPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_PULSE = 2'd2,
    ST_WAIT  = 2'd3
  } krgState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } krgStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/krgDatapath.sv
module krgDatapath
  import krgPkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int NUM_SLOTS = 3,
  parameter int CNT_W     = 16,
  parameter int HOLD_DIV  = 1000,
  parameter int PULSE_DIV = 500
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [(1<<CODE_W)-1:0]             keyPressed,
  input  logic [NUM_SLOTS-1:0][CODE_W-1:0]   slotCodes,
  input  logic [2:0]                         trigTime,
  input  logic [1:0]                         pulseWidth,
  input  krgStrobe_t                         strobe,
  output logic                               combo,
  output logic                               holdSkip,
  output logic                               holdDone,
  output logic                               pulseDone
);
  logic [NUM_SLOTS-1:0] slotOk;
  logic [NUM_SLOTS-1:0] slotArmed;
  logic [CNT_W-1:0]     cnt;
  logic [CNT_W-1:0]     holdTarget;
  logic [CNT_W-1:0]     pulseTarget;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    assign slotArmed[s] = (slotCodes[s] != '0);
    assign slotOk[s]    = !slotArmed[s] || keyPressed[slotCodes[s]];
  end

  assign combo = (&slotOk) && (|slotArmed);

  assign holdTarget  = CNT_W'(trigTime) * CNT_W'(HOLD_DIV);
  assign pulseTarget = CNT_W'(PULSE_DIV) << pulseWidth;

  assign holdSkip  = (trigTime == 3'd0);
  assign holdDone  = (cnt == holdTarget - CNT_W'(1));
  assign pulseDone = (cnt == pulseTarget - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else if (strobe.cntInc) cnt <= cnt + CNT_W'(1);
  end
endmodule

// File: rtl/krgControl.sv
module krgControl
  import krgPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       combo,
  input  logic       holdSkip,
  input  logic       holdDone,
  input  logic       pulseDone,
  output krgStrobe_t strobe,
  output logic       pulseOn
);
  krgState_e st, stNext;

  always_comb begin
    stNext = st;
    strobe = '0;
    case (st)
      ST_IDLE: begin
        if (combo) begin
          strobe.cntClr = 1'b1;
          stNext = holdSkip ? ST_PULSE : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (!combo) begin
          strobe.cntClr = 1'b1;
          stNext = ST_IDLE;
        end else if (holdDone) begin
          strobe.cntClr = 1'b1;
          stNext = ST_PULSE;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_PULSE: begin
        if (pulseDone) begin
          strobe.cntClr = 1'b1;
          stNext = ST_WAIT;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_WAIT: begin
        if (!combo) stNext = ST_IDLE;
      end
      default: stNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  assign pulseOn = (st == ST_PULSE);
endmodule

// File: rtl/keyComboReset.sv
module keyComboReset
  import krgPkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int HOLD_DIV  = 1000,
  parameter int PULSE_DIV = 500
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [(1<<CODE_W)-1:0]    keyPressed,
  input  logic [CODE_W-1:0]         g1CodeA,
  input  logic [CODE_W-1:0]         g1CodeB,
  input  logic [CODE_W-1:0]         g1CodeC,
  input  logic [CODE_W-1:0]         g2CodeA,
  input  logic [CODE_W-1:0]         g2CodeB,
  input  logic [2:0]                trigTime,
  input  logic [1:0]                pulseWidth,
  input  logic                      passThruEn,
  input  logic                      extRstN,
  input  logic                      activeHigh,
  output logic                      rst1Out,
  output logic                      rst2Out
);
  localparam int HOLD_MAX  = 7 * HOLD_DIV;
  localparam int PULSE_MAX = 8 * PULSE_DIV;
  localparam int CNT_W     = $clog2(maxOf(HOLD_MAX, PULSE_MAX) + 1);
  localparam int NUM_GEN   = 2;

  logic [NUM_GEN-1:0] combo;
  logic [NUM_GEN-1:0] pulseOn;

  for (genvar g = 0; g < NUM_GEN; g++) begin : gGen
    localparam int NS = (g == 0) ? 3 : 2;
    logic [NS-1:0][CODE_W-1:0] codes;
    krgStrobe_t strobe;
    logic holdSkip, holdDone, pulseDone;

    if (g == 0) begin : gCodes1
      assign codes = {g1CodeC, g1CodeB, g1CodeA};
    end else begin : gCodes2
      assign codes = {g2CodeB, g2CodeA};
    end

    krgDatapath #(
      .CODE_W(CODE_W), .NUM_SLOTS(NS), .CNT_W(CNT_W),
      .HOLD_DIV(HOLD_DIV), .PULSE_DIV(PULSE_DIV)
    ) uDp (
      .clk(clk), .rstN(rstN), .keyPressed(keyPressed), .slotCodes(codes),
      .trigTime(trigTime), .pulseWidth(pulseWidth), .strobe(strobe),
      .combo(combo[g]), .holdSkip(holdSkip), .holdDone(holdDone),
      .pulseDone(pulseDone)
    );

    krgControl uCtl (
      .clk(clk), .rstN(rstN), .combo(combo[g]), .holdSkip(holdSkip),
      .holdDone(holdDone), .pulseDone(pulseDone), .strobe(strobe),
      .pulseOn(pulseOn[g])
    );
  end

  logic rst1Asserted, rst2Asserted;
  assign rst1Asserted = pulseOn[0] || (passThruEn && !extRstN);
  assign rst2Asserted = pulseOn[1];

  assign rst1Out = activeHigh ? rst1Asserted : !rst1Asserted;
  assign rst2Out = activeHigh ? rst2Asserted : !rst2Asserted;
endmodule

// File: rtl/keyComboResetChk.sv
module keyComboResetChk #(
  parameter int HOLD_DIV  = 4,
  parameter int PULSE_DIV = 3
) (
  input logic       clk,
  input logic       rstN,
  input logic       pulse1,
  input logic       pulse2,
  input logic       combo1,
  input logic       combo2,
  input logic [2:0] trigTime,
  input logic [1:0] pulseWidth,
  input logic       passThruEn,
  input logic       extRstN,
  input logic       activeHigh,
  input logic       rst1Out
);
  int pulseRun1, pulseRun2, comboRun1;
  int expWidth, expHold;

  assign expWidth = PULSE_DIV << pulseWidth;
  assign expHold  = int'(trigTime) * HOLD_DIV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseRun1 <= 0;
      pulseRun2 <= 0;
      comboRun1 <= 0;
    end else begin
      pulseRun1 <= pulse1 ? pulseRun1 + 1 : 0;
      pulseRun2 <= pulse2 ? pulseRun2 + 1 : 0;
      comboRun1 <= combo1 ? comboRun1 + 1 : 0;
    end
  end

  // R6 R7
  pulse1_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulse1) |-> pulseRun1 == expWidth);

  // R6
  pulse2_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulse2) |-> pulseRun2 == expWidth);

  // R4
  hold_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(pulse1) && trigTime != 3'd0) |-> comboRun1 >= expHold);

  // R2
  combo2_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulse2) |-> $past(combo2));

  // R10
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rstN)
    (passThruEn && !extRstN) |-> rst1Out == activeHigh);
endmodule

bind keyComboReset keyComboResetChk #(.HOLD_DIV(HOLD_DIV), .PULSE_DIV(PULSE_DIV)) uChk (
  .clk(clk), .rstN(rstN), .pulse1(pulseOn[0]), .pulse2(pulseOn[1]),
  .combo1(combo[0]), .combo2(combo[1]), .trigTime(trigTime),
  .pulseWidth(pulseWidth), .passThruEn(passThruEn), .extRstN(extRstN),
  .activeHigh(activeHigh), .rst1Out(rst1Out)
);

// File: tb/sim_keyComboReset.sv
module sim_keyComboReset;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 4;
  localparam int HOLD_DIV   = 4;
  localparam int PULSE_DIV  = 3;
  localparam int NK         = 1 << CODE_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NK-1:0] keyPressed = '0;
  logic [CODE_W-1:0] g1CodeA = 4'd3, g1CodeB = 4'd7, g1CodeC = 4'd12;
  logic [CODE_W-1:0] g2CodeA = 4'd5, g2CodeB = 4'd9;
  logic [2:0] trigTime = 3'd1;
  logic [1:0] pulseWidth = 2'd0;
  logic passThruEn = 1'b0, extRstN = 1'b1, activeHigh = 1'b0;
  logic rst1Out, rst2Out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyComboReset #(.CODE_W(CODE_W), .HOLD_DIV(HOLD_DIV), .PULSE_DIV(PULSE_DIV)) u0 (
    .clk(clk), .rstN(rstN), .keyPressed(keyPressed),
    .g1CodeA(g1CodeA), .g1CodeB(g1CodeB), .g1CodeC(g1CodeC),
    .g2CodeA(g2CodeA), .g2CodeB(g2CodeB), .trigTime(trigTime),
    .pulseWidth(pulseWidth), .passThruEn(passThruEn), .extRstN(extRstN),
    .activeHigh(activeHigh), .rst1Out(rst1Out), .rst2Out(rst2Out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [NK-1:0] keyOf(input logic [CODE_W-1:0] c);
    logic [NK-1:0] v = '0;
    v[c] = 1'b1;
    return v;
  endfunction

  // Press keys, run maxC cycles, record first asserted sample and asserted counts.
  task automatic runCombo(input logic [NK-1:0] keys, input int maxC, input bit relOnAssert,
                          output int firstK, output int w1, output int w2);
    @(negedge clk);
    keyPressed = keys;
    firstK = 0; w1 = 0; w2 = 0;
    for (int k = 1; k <= maxC; k++) begin
      @(posedge clk); #1;
      if (rst1Out == activeHigh) begin
        w1++;
        if (firstK == 0) firstK = k;
        if (relOnAssert) keyPressed = '0;
      end
      if (rst2Out == activeHigh) begin
        w2++;
        if (firstK == 0) firstK = k;
      end
    end
    keyPressed = '0;
    repeat (3) @(posedge clk);
  endtask

  logic [NK-1:0] full1, full2;
  int fk, w1, w2, hExp, pExp;

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    full1 = keyOf(g1CodeA) | keyOf(g1CodeB) | keyOf(g1CodeC);
    full2 = keyOf(g2CodeA) | keyOf(g2CodeB);
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state, active-low idle is 1
    check(rst1Out == 1'b1 && rst2Out == 1'b1, "R9 reset idle", {rst1Out, rst2Out}, 3);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(posedge clk);

    // R4 R6 full timing sweep on generator 1
    for (int t = 0; t < 8; t++) begin
      for (int p = 0; p < 4; p++) begin
        trigTime = 3'(t); pulseWidth = 2'(p);
        hExp = t * HOLD_DIV; pExp = PULSE_DIV << p;
        runCombo(full1, hExp + pExp + 6, 1'b0, fk, w1, w2);
        check(fk == hExp + 1, "R4 hold delay", fk, hExp + 1);
        check(w1 == pExp, "R6 pulse width", w1, pExp);
        check(w2 == 0, "R11 gen2 idle", w2, 0);
      end
    end

    // R1 subsets of generator 1 chord
    trigTime = 3'd1; pulseWidth = 2'd0;
    for (int s = 0; s < 8; s++) begin
      logic [NK-1:0] ks;
      ks = (s[0] ? keyOf(g1CodeA) : '0) | (s[1] ? keyOf(g1CodeB) : '0) |
           (s[2] ? keyOf(g1CodeC) : '0);
      runCombo(ks, 20, 1'b0, fk, w1, w2);
      check(w1 == ((s == 7) ? PULSE_DIV : 0), "R1 subset match", w1, (s == 7) ? PULSE_DIV : 0);
    end

    // R2 subsets of generator 2 chord, pulse width sweep
    for (int s = 0; s < 4; s++) begin
      logic [NK-1:0] ks;
      ks = (s[0] ? keyOf(g2CodeA) : '0) | (s[1] ? keyOf(g2CodeB) : '0);
      runCombo(ks, 20, 1'b0, fk, w1, w2);
      check(w2 == ((s == 3) ? PULSE_DIV : 0), "R2 subset match", w2, (s == 3) ? PULSE_DIV : 0);
      check(w1 == 0, "R11 gen1 idle", w1, 0);
    end
    for (int p = 0; p < 4; p++) begin
      pulseWidth = 2'(p);
      runCombo(full2, HOLD_DIV + (PULSE_DIV << p) + 6, 1'b0, fk, w1, w2);
      check(w2 == (PULSE_DIV << p), "R2 pulse width", w2, PULSE_DIV << p);
      check(fk == HOLD_DIV + 1, "R2 hold delay", fk, HOLD_DIV + 1);
    end

    // R7 release on the first asserted cycle
    trigTime = 3'd1; pulseWidth = 2'd3;
    runCombo(full1, HOLD_DIV + 30, 1'b1, fk, w1, w2);
    check(w1 == PULSE_DIV * 8, "R7 full width after release", w1, PULSE_DIV * 8);

    // R8 hold long after pulse, then re-press
    pulseWidth = 2'd0;
    runCombo(full1, HOLD_DIV + PULSE_DIV + 60, 1'b0, fk, w1, w2);
    check(w1 == PULSE_DIV, "R8 no refire while held", w1, PULSE_DIV);
    runCombo(full1, HOLD_DIV + PULSE_DIV + 6, 1'b0, fk, w1, w2);
    check(fk == HOLD_DIV + 1, "R8 refire after re-press", fk, HOLD_DIV + 1);

    // R5 release mid hold restarts the full hold
    trigTime = 3'd2;
    @(negedge clk); keyPressed = full1;
    w1 = 0;
    repeat (5) begin
      @(posedge clk); #1;
      if (rst1Out == activeHigh) w1++;
    end
    check(w1 == 0, "R5 no pulse before hold", w1, 0);
    @(negedge clk); keyPressed = '0;
    runCombo(full1, 2 * HOLD_DIV + PULSE_DIV + 6, 1'b0, fk, w1, w2);
    check(fk == 2 * HOLD_DIV + 1, "R5 hold restarted", fk, 2 * HOLD_DIV + 1);

    // R3 unused slot and all-unused generator
    trigTime = 3'd1;
    g1CodeC = '0;
    runCombo(keyOf(g1CodeA) | keyOf(g1CodeB), 20, 1'b0, fk, w1, w2);
    check(w1 == PULSE_DIV, "R3 zero slot satisfied", w1, PULSE_DIV);
    g1CodeA = '0; g1CodeB = '0;
    runCombo('1, 40, 1'b0, fk, w1, w2);
    check(w1 == 0, "R3 all zero never fires", w1, 0);
    g1CodeA = 4'd3; g1CodeB = 4'd7; g1CodeC = 4'd12;

    // R9 active-high polarity
    @(negedge clk); activeHigh = 1'b1;
    #1;
    check(rst1Out == 1'b0 && rst2Out == 1'b0, "R9 active-high idle", {rst1Out, rst2Out}, 0);
    runCombo(full1, HOLD_DIV + PULSE_DIV + 6, 1'b0, fk, w1, w2);
    check(w1 == PULSE_DIV && fk == HOLD_DIV + 1, "R9 active-high pulse", w1, PULSE_DIV);
    @(negedge clk); activeHigh = 1'b0;

    // R10 pass-through
    @(negedge clk); passThruEn = 1'b1; extRstN = 1'b0;
    @(posedge clk); #1;
    check(rst1Out == 1'b0, "R10 pass-through asserts rst1", rst1Out, 0);
    check(rst2Out == 1'b1, "R10 rst2 unaffected", rst2Out, 1);
    @(negedge clk); passThruEn = 1'b0;
    @(posedge clk); #1;
    check(rst1Out == 1'b1, "R10 disabled pass-through", rst1Out, 1);
    @(negedge clk); extRstN = 1'b1;
    repeat (2) @(posedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule